// File: doc/BRIEF.md
# Wireless Power Receiver Packet Modulator

This block turns packet requests from a receiver-side controller into the load-modulation waveform that an inductive power transmitter demodulates. Each accepted request becomes a framed packet: a run of one-bits as preamble, a header byte, one to `MAX_MSG` message bytes and a checksum byte. The bits leave on a single output pin in differential biphase form, one bit cell every `2*HALF_CYCLES` clock cycles. With the default of 50,000 half-cell cycles at 200 MHz, this gives the 2 kb/s link rate.

The block tracks where the link stands after power-up. It admits only a signal-strength packet first, then a configuration packet, then an identification packet. Only after these three does it accept control-error or user packets. An end-power packet may be requested at any point. A shutdown input overrides everything while the block is idle: it sends an end-power packet carrying the given reason code at once, and the startup order then begins again. The controller watches `busy` and `done` to know when a request has been taken and when the packet has finished.

Top module: `wpr_pkt_mod`

## Requirements
- R1: After reset, `busy`, `done` and `modOut` are all 0.
- R2: Every bit cell lasts exactly 2*HALF_CYCLES clock cycles. `modOut` toggles at the start of every cell. It toggles a second time, HALF_CYCLES cycles into the cell, only when the bit is a one.
- R3: A packet is PREAMBLE_BITS one-bits, then the header byte, the message bytes and a checksum equal to the XOR of the header and all message bytes. Each byte is sent as a 0 start bit, eight data bits least-significant first, an odd parity bit (the nine bits hold an odd number of ones) and a 1 stop bit.
- R4: `busy` rises on the same clock edge as the first preamble toggle. It stays high until the stop bit of the checksum ends. `done` is high for exactly the one cycle in which `busy` has just fallen.
- R5: Kind codes on `reqKind` are 0 signal strength, 1 configuration, 2 identification, 3 control error, 4 end power and 5 user. After reset, only kind 0 is accepted, then only kind 1, then only kind 2. A request out of this order is ignored: `busy` stays low and `modOut` does not move.
- R6: Kinds 3 and 5 are accepted only after the three startup packets have been taken. Once that has happened, kinds 0, 1 and 2 are ignored.
- R7: While idle, a high `shutdownReq` wins over any request in any phase. It sends an end-power packet with header 0x02 and one message byte holding the reason.
- R8: The legal reason codes are 0x00, 0x01, 0x02, 0x03, 0x04, 0x06, 0x07 and 0x08. Any other code is sent as 0x00.
- R9: A kind 4 request is accepted in any phase. It is sent with header 0x02 and a single byte (message byte 0, checked as in R8), whatever header and length were supplied. Once any end-power packet has been accepted, the startup order restarts at kind 0.
- R10: Requests presented while `busy` is high are ignored and do not alter the packet in flight.
- R11: `reqLen` selects 1 to MAX_MSG message bytes, taken from `reqMsg` byte 0 upward. A length of 0 is sent as 1, and a length above MAX_MSG is sent as MAX_MSG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Packet request present |
| reqKind | input | 3 | Packet kind code (see R5) |
| reqHeader | input | 8 | Header byte for non-end-power kinds |
| reqLen | input | LEN_W (3) | Number of message bytes |
| reqMsg | input | 8*MAX_MSG (32) | Message bytes, byte 0 in bits 7:0 |
| shutdownReq | input | 1 | Shutdown condition present |
| shutdownReason | input | 8 | End-power reason code for a shutdown |
| busy | output | 1 | Packet being modulated |
| done | output | 1 | One-cycle pulse at the end of a packet |
| modOut | output | 1 | Load-modulation drive, differential biphase |

## Verification
The accepting clock edge is the one where the request is sampled. On that same edge `busy` goes high and `modOut` makes its first toggle. The mid-cell toggle of a one falls HALF_CYCLES edges later, and each following cell starts 2*HALF_CYCLES edges after the one before. `done` is high in the cycle that follows the last cell's closing edge.

The bench drives inputs on falling edges and samples each half-cell at a falling edge one cycle into that half. This lets it read both half levels of every cell and the level change across each boundary. It then checks `done` and `busy` exactly at the falling edge after the final cell, and `done` again one cycle later. To show that an ignored request had no effect, the bench holds it for several cycles and watches `busy` and `modOut` at every falling edge.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

  typedef enum logic [2:0] {
    KIND_SIGNAL  = 3'd0,
    KIND_CONFIG  = 3'd1,
    KIND_IDENT   = 3'd2,
    KIND_CTRLERR = 3'd3,
    KIND_ENDPWR  = 3'd4,
    KIND_USER    = 3'd5
  } pkt_kind_e;

  typedef enum logic [1:0] {
    PH_SIGNAL = 2'd0,
    PH_CONFIG = 2'd1,
    PH_IDENT  = 2'd2,
    PH_RUN    = 2'd3
  } link_phase_e;

  // Strobes from the sequencer to the cell encoder.
  typedef struct packed {
    logic startCell;
    logic bitVal;
  } cell_cmd_t;

  localparam logic [7:0] ENDPWR_HEADER = 8'h02;
  localparam logic [3:0] LAST_FRAME_BIT = 4'd10;

  function automatic logic reasonLegal(input logic [7:0] code);
    return (code <= 8'h04) || ((code >= 8'h06) && (code <= 8'h08));
  endfunction

endpackage

// File: rtl/wpr_cell_enc.sv
module wpr_cell_enc
  import wpr_pkg::*;
#(
  parameter int HALF_CYCLES = 50000
) (
  input  logic      clk,
  input  logic      rstN,
  input  cell_cmd_t cmd,
  output logic      cellEnd,
  output logic      modOut
);

  localparam int CELL_CYCLES = 2 * HALF_CYCLES;
  localparam int CNT_W = (CELL_CYCLES > 2) ? $clog2(CELL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CELL_CYCLES - 1);
  localparam logic [CNT_W-1:0] CNT_MID = CNT_W'(HALF_CYCLES - 1);

  logic             running;
  logic [CNT_W-1:0] cellCnt;
  logic             curBit;

  assign cellEnd = running && (cellCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cellCnt <= '0;
      curBit  <= 1'b0;
      modOut  <= 1'b0;
    end else if (cmd.startCell) begin
      running <= 1'b1;
      cellCnt <= '0;
      curBit  <= cmd.bitVal;
      modOut  <= ~modOut;
    end else if (running) begin
      if (cellEnd) running <= 1'b0;
      else         cellCnt <= cellCnt + 1'b1;
      if (curBit && (cellCnt == CNT_MID)) modOut <= ~modOut;
    end
  end

  // R2: the sequencer never cuts a cell short.
  assert_cell_whole_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.startCell |-> (!running || cellEnd));

  // R2: a cell that has just started holds its level on the next edge.
  assert_cell_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (running && (cellCnt == '0) && !cmd.startCell && (HALF_CYCLES > 1)) |=> $stable(modOut));

endmodule

// File: rtl/wpr_pkt_seq.sv
module wpr_pkt_seq
  import wpr_pkg::*;
#(
  parameter int PREAMBLE_BITS = 11,
  parameter int MAX_MSG       = 4,
  parameter int LEN_W         = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqKind,
  input  logic [7:0]           reqHeader,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [8*MAX_MSG-1:0] reqMsg,
  input  logic                 shutdownReq,
  input  logic [7:0]           shutdownReason,
  input  logic                 cellEnd,
  output cell_cmd_t            cmd,
  output logic                 busy,
  output logic                 done
);

  localparam int PRE_W  = $clog2(PREAMBLE_BITS + 1);
  localparam int BYTE_W = $clog2(MAX_MSG + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_BYTE} seq_state_e;

  seq_state_e           st;
  link_phase_e          phase;
  logic [7:0]           capHdr;
  logic [8*MAX_MSG-1:0] capMsg;
  logic [LEN_W-1:0]     capLen;
  logic                 capEpt;
  logic [PRE_W-1:0]     preCnt;
  logic [BYTE_W-1:0]    byteIdx;
  logic [3:0]           bitIdx;

  logic       kindOk, takeShut, takeReq, accept, newEpt, lastBit, nextBitVal;
  logic [7:0] rawReason, cleanReason, checkSum, curByte;
  logic [LEN_W-1:0] lenEff;

  function automatic logic frameBit(input logic [7:0] b, input logic [3:0] k);
    if (k == 4'd0)      return 1'b0;
    else if (k <= 4'd8) return b[3'(k - 4'd1)];
    else if (k == 4'd9) return ~^b;
    else                return 1'b1;
  endfunction

  // Admission of a new packet.
  always_comb begin
    case (pkt_kind_e'(reqKind))
      KIND_SIGNAL:             kindOk = (phase == PH_SIGNAL);
      KIND_CONFIG:             kindOk = (phase == PH_CONFIG);
      KIND_IDENT:              kindOk = (phase == PH_IDENT);
      KIND_CTRLERR, KIND_USER: kindOk = (phase == PH_RUN);
      KIND_ENDPWR:             kindOk = 1'b1;
      default:                 kindOk = 1'b0;
    endcase
    takeShut    = (st == ST_IDLE) && shutdownReq;
    takeReq     = (st == ST_IDLE) && !shutdownReq && reqValid && kindOk;
    accept      = takeShut || takeReq;
    newEpt      = takeShut || (pkt_kind_e'(reqKind) == KIND_ENDPWR);
    rawReason   = takeShut ? shutdownReason : reqMsg[7:0];
    cleanReason = reasonLegal(rawReason) ? rawReason : 8'h00;
    if (reqLen == '0)                   lenEff = LEN_W'(1);
    else if (int'(reqLen) > MAX_MSG)    lenEff = LEN_W'(MAX_MSG);
    else                                lenEff = reqLen;
  end

  // Byte currently on the wire and the checksum.
  always_comb begin
    checkSum = capHdr;
    for (int i = 0; i < MAX_MSG; i++)
      if (i < int'(capLen)) checkSum = checkSum ^ capMsg[8*i +: 8];
    curByte = checkSum;
    if (byteIdx == '0) curByte = capHdr;
    for (int i = 0; i < MAX_MSG; i++)
      if ((int'(byteIdx) == i + 1) && (i < int'(capLen))) curByte = capMsg[8*i +: 8];
  end

  always_comb begin
    lastBit = (st == ST_BYTE) && (bitIdx == LAST_FRAME_BIT) &&
              (int'(byteIdx) == int'(capLen) + 1);
    case (st)
      ST_PRE:  nextBitVal = (int'(preCnt) != PREAMBLE_BITS - 1);
      ST_BYTE: nextBitVal = (bitIdx == LAST_FRAME_BIT) ? 1'b0 : frameBit(curByte, bitIdx + 4'd1);
      default: nextBitVal = 1'b1;
    endcase
    cmd.startCell = accept || (cellEnd && !lastBit);
    cmd.bitVal    = accept ? 1'b1 : nextBitVal;
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= ST_IDLE;
      phase   <= PH_SIGNAL;
      capHdr  <= '0;
      capMsg  <= '0;
      capLen  <= LEN_W'(1);
      capEpt  <= 1'b0;
      preCnt  <= '0;
      byteIdx <= '0;
      bitIdx  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st     <= ST_PRE;
        preCnt <= '0;
        capEpt <= newEpt;
        capHdr <= newEpt ? ENDPWR_HEADER : reqHeader;
        capLen <= newEpt ? LEN_W'(1) : lenEff;
        capMsg <= newEpt ? (8*MAX_MSG)'(cleanReason) : reqMsg;
        if (newEpt)               phase <= PH_SIGNAL;
        else if (phase != PH_RUN) phase <= link_phase_e'(phase + 2'd1);
      end else if (cellEnd) begin
        case (st)
          ST_PRE: begin
            if (int'(preCnt) == PREAMBLE_BITS - 1) begin
              st      <= ST_BYTE;
              byteIdx <= '0;
              bitIdx  <= '0;
            end else begin
              preCnt <= preCnt + 1'b1;
            end
          end
          ST_BYTE: begin
            if (bitIdx == LAST_FRAME_BIT) begin
              if (lastBit) begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end else begin
                byteIdx <= byteIdx + 1'b1;
                bitIdx  <= '0;
              end
            end else begin
              bitIdx <= bitIdx + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_fall_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phase != $past(phase)) |-> ((phase == link_phase_e'($past(phase) + 2'd1)) || (phase == PH_SIGNAL)));

  assert_reason_legal_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && capEpt) |-> reasonLegal(capMsg[7:0]));

  assert_ept_frame_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && capEpt) |-> ((capHdr == ENDPWR_HEADER) && (capLen == LEN_W'(1))));

  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(capHdr) && $stable(capLen) && $stable(capMsg)));

  assert_len_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ((capLen != '0) && (int'(capLen) <= MAX_MSG)));

endmodule

// File: rtl/wpr_pkt_mod.sv
module wpr_pkt_mod
  import wpr_pkg::*;
#(
  parameter int HALF_CYCLES   = 50000,
  parameter int PREAMBLE_BITS = 11,
  parameter int MAX_MSG       = 4,
  localparam int LEN_W        = $clog2(MAX_MSG + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [2:0]           reqKind,
  input  logic [7:0]           reqHeader,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [8*MAX_MSG-1:0] reqMsg,
  input  logic                 shutdownReq,
  input  logic [7:0]           shutdownReason,
  output logic                 busy,
  output logic                 done,
  output logic                 modOut
);

  cell_cmd_t cellCmd;
  logic      cellEnd;

  wpr_pkt_seq #(
    .PREAMBLE_BITS(PREAMBLE_BITS),
    .MAX_MSG      (MAX_MSG),
    .LEN_W        (LEN_W)
  ) i_seq (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .reqKind       (reqKind),
    .reqHeader     (reqHeader),
    .reqLen        (reqLen),
    .reqMsg        (reqMsg),
    .shutdownReq   (shutdownReq),
    .shutdownReason(shutdownReason),
    .cellEnd       (cellEnd),
    .cmd           (cellCmd),
    .busy          (busy),
    .done          (done)
  );

  wpr_cell_enc #(
    .HALF_CYCLES(HALF_CYCLES)
  ) i_enc (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cellCmd),
    .cellEnd(cellEnd),
    .modOut (modOut)
  );

endmodule

// File: tb/test_wpr_pkt_mod.sv
module test_wpr_pkt_mod;

  localparam int HALF = 4;
  localparam int PRE  = 11;
  localparam int MAXM = 4;
  localparam int LW   = $clog2(MAXM + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    reqKind = '0;
  logic [7:0]    reqHeader = '0;
  logic [LW-1:0] reqLen = '0;
  logic [31:0]   reqMsg = '0;
  logic          shutdownReq = 1'b0;
  logic [7:0]    shutdownReason = '0;
  logic          busy, done, modOut;

  always #2.5 clk = ~clk;

  wpr_pkt_mod #(.HALF_CYCLES(HALF), .PREAMBLE_BITS(PRE), .MAX_MSG(MAXM)) i_wpr_pkt_mod (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind), .reqHeader(reqHeader),
    .reqLen(reqLen), .reqMsg(reqMsg), .shutdownReq(shutdownReq),
    .shutdownReason(shutdownReason), .busy(busy), .done(done), .modOut(modOut)
  );

  int checks = 0;
  int failures = 0;
  bit expBits [0:199];
  int expN = 0;
  logic levelBefore;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic buildExp(input logic [7:0] hdr, input int len, input logic [31:0] msg);
    logic [7:0] sum, b;
    sum = hdr;
    for (int k = 0; k < len; k++) sum = sum ^ msg[8*k +: 8];
    expN = 0;
    for (int i = 0; i < PRE; i++) begin expBits[expN] = 1'b1; expN++; end
    for (int k = 0; k < len + 2; k++) begin
      b = (k == 0) ? hdr : ((k <= len) ? msg[8*(k-1) +: 8] : sum);
      expBits[expN] = 1'b0; expN++;
      for (int j = 0; j < 8; j++) begin expBits[expN] = b[j]; expN++; end
      expBits[expN] = ~^b; expN++;
      expBits[expN] = 1'b1; expN++;
    end
  endtask

  // Present a request at a falling edge; acceptance happens on the next rising edge.
  task automatic launch(input logic [2:0] kind, input logic [7:0] hdr, input int len,
                        input logic [31:0] msg, input bit shut, input logic [7:0] reason,
                        input bit alsoReq);
    @(negedge clk);
    levelBefore = modOut;
    reqValid = alsoReq; reqKind = kind; reqHeader = hdr; reqLen = LW'(len); reqMsg = msg;
    shutdownReq = shut; shutdownReason = reason;
    @(posedge clk);
  endtask

  // Decode one packet after its accepting edge and compare with expBits.
  task automatic capture(input string req, input bit busyReq);
    int nBad = 0, bndBad = 0, busyBad = 0;
    logic a, b, prev;
    prev = levelBefore;
    @(negedge clk);
    shutdownReq = 1'b0;
    if (busyReq) begin
      reqValid = 1'b1; reqKind = 3'd3; reqHeader = 8'hEE; reqLen = LW'(2); reqMsg = 32'h0000_9999;
    end else begin
      reqValid = 1'b0;
    end
    for (int i = 0; i < expN; i++) begin
      @(negedge clk); a = modOut; if (!busy) busyBad++;
      repeat (HALF) @(negedge clk); b = modOut;
      repeat (HALF - 1) @(negedge clk);
      if (a == prev) bndBad++;
      if ((a != b) != expBits[i]) nBad++;
      prev = b;
    end
    reqValid = 1'b0;
    chk(nBad == 0, req, "decoded bit mismatches", nBad, 0);
    chk(bndBad == 0, "R2", "missing cell-boundary toggles", bndBad, 0);
    chk(busyBad == 0, "R4", "busy low inside packet", busyBad, 0);
    chk(done && !busy, "R4", "done/busy after last cell", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done && !busy, "R4", "done lasts one cycle", {done, busy}, 2'b00);
  endtask

  task automatic expectIgnored(input logic [2:0] kind, input string req);
    int moved = 0;
    logic lvl;
    @(negedge clk);
    lvl = modOut;
    reqValid = 1'b1; reqKind = kind; reqHeader = 8'h33; reqLen = LW'(1); reqMsg = 32'h5;
    for (int i = 0; i < 2 * HALF + 2; i++) begin
      @(negedge clk);
      if (busy || (modOut != lvl)) moved++;
    end
    reqValid = 1'b0;
    chk(moved == 0, req, "out-of-order request reacted", moved, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!busy && !done && !modOut, "R1", "outputs in reset", {busy, done, modOut}, 3'b000);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !modOut, "R1", "outputs after reset", {busy, done, modOut}, 3'b000);
  endtask

  task automatic t_order_before_start();
    expectIgnored(3'd1, "R5");
    expectIgnored(3'd2, "R5");
    expectIgnored(3'd3, "R6");
    expectIgnored(3'd5, "R6");
  endtask

  task automatic t_startup();
    buildExp(8'h01, 1, 32'h7A);
    launch(3'd0, 8'h01, 1, 32'h7A, 1'b0, 8'h0, 1'b1);
    capture("R3", 1'b0);
    expectIgnored(3'd0, "R5");
    expectIgnored(3'd2, "R5");
    buildExp(8'h51, 1, 32'hC3);                       // length 0 sent as 1
    launch(3'd1, 8'h51, 0, 32'h0000_00C3, 1'b0, 8'h0, 1'b1);
    capture("R11", 1'b0);
    buildExp(8'h71, 4, 32'h1122_3344);                // length 7 clipped to 4
    launch(3'd2, 8'h71, 7, 32'h1122_3344, 1'b0, 8'h0, 1'b1);
    capture("R11", 1'b0);
  endtask

  task automatic t_run();
    expectIgnored(3'd0, "R6");
    expectIgnored(3'd1, "R6");
    buildExp(8'h03, 1, 32'hFE);
    launch(3'd3, 8'h03, 1, 32'hFE, 1'b0, 8'h0, 1'b1);
    capture("R6", 1'b0);
    buildExp(8'h18, 2, 32'h0000_5AA5);
    launch(3'd5, 8'h18, 2, 32'h0000_5AA5, 1'b0, 8'h0, 1'b1);
    capture("R10", 1'b1);
  endtask

  task automatic t_shutdown();
    buildExp(8'h02, 1, 32'h03);
    launch(3'd3, 8'h03, 1, 32'hAA, 1'b1, 8'h03, 1'b1);
    capture("R7", 1'b0);
    expectIgnored(3'd3, "R9");
    buildExp(8'h01, 1, 32'h40);
    launch(3'd0, 8'h01, 1, 32'h40, 1'b0, 8'h0, 1'b1);
    capture("R9", 1'b0);
  endtask

  task automatic t_reasons();
    buildExp(8'h02, 1, 32'h00);
    launch(3'd0, 8'h00, 1, 32'h0, 1'b1, 8'h05, 1'b0);
    capture("R8", 1'b0);
    buildExp(8'h02, 1, 32'h08);
    launch(3'd0, 8'h00, 1, 32'h0, 1'b1, 8'h08, 1'b0);
    capture("R8", 1'b0);
    buildExp(8'h02, 1, 32'h00);
    launch(3'd0, 8'h00, 1, 32'h0, 1'b1, 8'hFF, 1'b0);
    capture("R8", 1'b0);
  endtask

  task automatic t_ept_request();
    buildExp(8'h02, 1, 32'h07);
    launch(3'd4, 8'h55, 3, 32'h0011_2207, 1'b0, 8'h0, 1'b1);
    capture("R9", 1'b0);
    buildExp(8'h02, 1, 32'h00);
    launch(3'd4, 8'h55, 1, 32'h0000_0009, 1'b0, 8'h0, 1'b1);
    capture("R8", 1'b0);
  endtask

  initial begin
    t_reset();
    t_order_before_start();
    t_startup();
    t_run();
    t_shutdown();
    t_reasons();
    t_ept_request();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule